// File: doc/BRIEF.md
# Byte-Addressed Serial EEPROM Target

This block is a target on a two-wire serial bus (I2C/SMBus style) that holds a 256-byte array of bytes. A controller writes to it to load an internal byte pointer and, optionally, to store bytes from that pointer onward. It reads from it to stream bytes out from the pointer. The pointer moves forward by one after every stored or returned byte and wraps from 255 to 0.

The bus lines come in as raw clock and data inputs and pass through two flip-flops each before any edge detection. The block pulls the data line low through a single drive-low output, and never drives it high. Several copies can share one bus. Each copy answers at a fixed base address plus a 3-bit strap index.

A separate image store is filled through a preload port. Every functional reset copies that image into the working array and clears the pointer. A sticky flag records that the device has been addressed. Only the power-on reset clears that flag.

Top module: `smb_eeprom_tgt`

## Requirements
- R1: The device answers at 7-bit address `BASE_ADDR + strap` (default base 0x50, strap 0..7) and ACKs it. It does not ACK other addresses and leaves the data line released for the rest of that transfer.
- R2: In a write transfer, the first byte after the address byte loads the pointer. The device ACKs every byte written to it.
- R3: Each further written byte is stored at the pointer, and the pointer then steps by one modulo 256, so 0xFF is followed by 0x00.
- R4: A read transfer returns the byte at the pointer, most significant bit first, and steps the pointer by one modulo 256 for each byte. Consecutive bytes therefore come from consecutive locations.
- R5: A write transfer that carries only the pointer byte changes no stored byte. A later read starts at that pointer.
- R6: A controller NACK after a read byte ends the transfer. The pointer is already one past the last byte sent, so the next read continues from there.
- R7: A repeated START restarts the address phase without changing the pointer.
- R8: While `rst_n` is low, the working array is reloaded from the image written through the preload port (`img_we`, `img_addr`, `img_data`), and the pointer is cleared to 0.
- R9: `touched` goes to 1 when the device is addressed, in either direction. It stays at 1 through `rst_n`, and only `por_n` clears it.
- R10: After any reset, and while the bus is idle, `sda_lo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including `touched` |
| rst_n | input | 1 | Functional reset, active low; reloads the array from the image |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_lo | output | 1 | 1 pulls the data line low; 0 releases it |
| strap | input | 3 | Address strap index added to the base address |
| img_we | input | 1 | Preload image write enable |
| img_addr | input | 8 | Preload image byte address |
| img_data | input | 8 | Preload image byte value |
| touched | output | 1 | Sticky flag: the device has been addressed since power-on |

## Verification
Each bus line passes through two synchroniser stages, and the block then compares the result with one more registered copy. An edge on the wire therefore reaches the state machine about three clocks later. An ACK or a read data bit appears on `sda_lo` one clock after that. The bench holds each bus half-period for eight clocks and reads the data line only just before it drops the clock line. That sample falls well after the design has settled and well before it next changes the line. Flags and reset effects are checked several clocks after the stimulus, on the falling clock edge. Expected read bytes come from a reference array that the bench updates itself. A driver task queues these bytes, and a monitor process compares each one as the controller finishes receiving a byte.

// File: rtl/smb_eeprom_tgt.sv
module smb_eeprom_tgt #(
  parameter logic [6:0] BASE_ADDR = 7'h50,
  parameter int         AW        = 8
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_lo,
  input  logic [2:0] strap,
  input  logic       img_we,
  input  logic [7:0] img_addr,
  input  logic [7:0] img_data,
  output logic       touched
);
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_AACK = 3'd2,
                         S_WDAT = 3'd3, S_WACK = 3'd4, S_RDAT = 3'd5,
                         S_RACK = 3'd6;

  logic [7:0]    img [DEPTH];
  logic [7:0]    mem [DEPTH];
  logic [1:0]    scl_sy, sda_sy;
  logic          scl_d, sda_d;
  logic [2:0]    st, bitc;
  logic [7:0]    sr, tx;
  logic [AW-1:0] ptr;
  logic          done, rw, first, mack;

  wire       scl       = scl_sy[1];
  wire       sda       = sda_sy[1];
  wire       scl_rise  = scl & ~scl_d;
  wire       scl_fall  = ~scl & scl_d;
  wire       start_c   = scl & scl_d & sda_d & ~sda;
  wire       stop_c    = scl & scl_d & ~sda_d & sda;
  wire [6:0] my_addr   = BASE_ADDR + {4'd0, strap};
  wire       hit       = sr[7:1] == my_addr;

  assign sda_lo = (st == S_AACK) | (st == S_WACK) | ((st == S_RDAT) & ~tx[7]);

  always_ff @(posedge clk)
    if (img_we) img[img_addr[AW-1:0]] <= img_data;

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl;                sda_d  <= sda;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n)
      touched <= 1'b0;
    else if (scl_fall && st == S_ADDR && done && hit)
      touched <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      st <= S_IDLE; bitc <= '0; done <= 1'b0; sr <= '0; tx <= '0;
      rw <= 1'b0; first <= 1'b0; mack <= 1'b0; ptr <= '0;
      mem <= img;
    end else if (start_c) begin
      st <= S_ADDR; bitc <= '0; done <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE;
    end else if (scl_rise) begin
      case (st)
        S_ADDR, S_WDAT: begin
          sr   <= {sr[6:0], sda};
          bitc <= bitc + 3'd1;
          if (bitc == 3'd7) done <= 1'b1;
        end
        S_RDAT: begin
          bitc <= bitc + 3'd1;
          if (bitc == 3'd7) done <= 1'b1;
        end
        S_RACK: mack <= ~sda;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (st)
        S_ADDR:
          if (done) begin
            done <= 1'b0;
            if (hit) begin st <= S_AACK; rw <= sr[0]; end
            else st <= S_IDLE;
          end
        S_AACK:
          if (rw) begin
            tx <= mem[ptr]; ptr <= ptr + 1'b1; st <= S_RDAT;
          end else begin
            st <= S_WDAT; first <= 1'b1;
          end
        S_WDAT:
          if (done) begin
            done <= 1'b0;
            st   <= S_WACK;
            if (first) begin
              ptr <= sr[AW-1:0]; first <= 1'b0;
            end else begin
              mem[ptr] <= sr; ptr <= ptr + 1'b1;
            end
          end
        S_WACK: st <= S_WDAT;
        S_RDAT:
          if (done) begin done <= 1'b0; st <= S_RACK; end
          else tx <= {tx[6:0], 1'b0};
        S_RACK:
          if (mack) begin
            tx <= mem[ptr]; ptr <= ptr + 1'b1; st <= S_RDAT;
          end else st <= S_IDLE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_eeprom_tgt_chk.sv
module smb_eeprom_tgt_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic          start_c,
  input logic          scl_fall,
  input logic          rw,
  input logic [2:0]    st,
  input logic [AW-1:0] ptr,
  input logic          touched,
  input logic          sda_lo
);
  // R9
  touched_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    touched |=> touched);

  // R8
  reset_ptr_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> (ptr == '0));

  // R10
  reset_release_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> !sda_lo);

  // R4
  rd_ptr_step_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (st == 3'd2 && rw && scl_fall) |=> (ptr == AW'($past(ptr) + 1'b1)));

  // R7
  restart_keep_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    start_c |=> (st == 3'd1 && ptr == $past(ptr)));
endmodule

bind smb_eeprom_tgt smb_eeprom_tgt_chk #(.AW(AW)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .start_c(start_c),
  .scl_fall(scl_fall), .rw(rw), .st(st), .ptr(ptr),
  .touched(touched), .sda_lo(sda_lo)
);

// File: tb/smb_eeprom_tgt_bench.sv
module smb_eeprom_tgt_bench;
  localparam int HP = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       por_n, rst_n, scl_m, sda_m, img_we, sda_lo, touched;
  logic [2:0] strap;
  logic [7:0] img_addr, img_data;
  wire        sda_line = sda_m & ~sda_lo;

  smb_eeprom_tgt u_smb_eeprom_tgt (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_lo(sda_lo), .strap(strap), .img_we(img_we), .img_addr(img_addr),
    .img_data(img_data), .touched(touched)
  );

  int total = 0, bad = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr;
  logic [6:0] dev;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] rx_b;
  event       rx_ev;

  function automatic logic [7:0] img_fn(int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(HP); scl_m = 1'b1; wt(HP);
    sda_m = 1'b0; wt(HP); scl_m = 1'b0; wt(HP);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(HP); scl_m = 1'b1; wt(HP); sda_m = 1'b1; wt(HP);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(HP); scl_m = 1'b1; wt(HP); scl_m = 1'b0;
    end
    sda_m = 1'b1; wt(HP); scl_m = 1'b1; wt(HP);
    ack = ~sda_line; scl_m = 1'b0; wt(HP);
  endtask

  task automatic recv(input logic ack_it);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(HP); scl_m = 1'b1; wt(HP); b[i] = sda_line; scl_m = 1'b0;
    end
    rx_b = b;
    -> rx_ev;
    sda_m = ~ack_it; wt(HP); scl_m = 1'b1; wt(HP); scl_m = 1'b0; wt(HP);
    sda_m = 1'b1;
  endtask

  task automatic expect_rd(string tag);
    exp_q.push_back(ref_mem[ref_ptr]);
    tag_q.push_back(tag);
    ref_ptr = ref_ptr + 8'd1;
  endtask

  task automatic read_n(int n, string tag);
    logic a;
    bus_start;
    send({dev, 1'b1}, a);
    check({tag, " addr ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      expect_rd(tag);
      recv(k < n - 1);
    end
    bus_stop;
  endtask

  task automatic write_seq(logic [7:0] p, logic [7:0] d [$], string tag);
    logic a;
    bus_start;
    send({dev, 1'b0}, a);
    check({tag, " addr ack"}, a, 1);
    send(p, a);
    check({tag, " ptr ack"}, a, 1);
    ref_ptr = p;
    foreach (d[k]) begin
      send(d[k], a);
      check({tag, " data ack"}, a, 1);
      ref_mem[ref_ptr] = d[k];
      ref_ptr = ref_ptr + 8'd1;
    end
    bus_stop;
  endtask

  initial begin : monitor
    forever begin
      @(rx_ev);
      if (exp_q.size() == 0) check("R4 unexpected byte", rx_b, 0);
      else check(tag_q.pop_front(), rx_b, exp_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    logic a;
    logic [7:0] d [$];
    por_n = 1'b0; rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    strap = 3'd0; img_we = 1'b0; img_addr = '0; img_data = '0;
    dev = 7'h50;
    wt(2);
    for (int i = 0; i < 256; i++) begin
      img_we = 1'b1; img_addr = 8'(i); img_data = img_fn(i); wt(1);
      ref_mem[i] = img_fn(i);
    end
    img_we = 1'b0; wt(3);
    check("R10 reset sda_lo", sda_lo, 0);
    check("R9 reset touched", touched, 0);
    por_n = 1'b1; wt(2); rst_n = 1'b1; wt(4);
    ref_ptr = 8'd0;

    read_n(2, "R8 read from cleared ptr");
    check("R9 touched after read", touched, 1);
    check("R10 idle sda_lo", sda_lo, 0);

    bus_start;
    send({7'h51, 1'b0}, a);
    check("R1 foreign address nack", a, 0);
    send(8'h33, a);
    check("R1 foreign data nack", a, 0);
    bus_stop;

    d = '{8'hA1, 8'hB2, 8'hC3};
    write_seq(8'h10, d, "R2 write");
    d = '{};
    write_seq(8'h10, d, "R5 ptr only");
    read_n(3, "R3 stored bytes");
    read_n(1, "R6 continue after nack");

    d = '{8'h5A, 8'h6B, 8'h7C};
    write_seq(8'hFE, d, "R3 wrap write");
    d = '{};
    write_seq(8'hFE, d, "R5 ptr only");
    read_n(4, "R4 read wrap");

    write_seq(8'h40, d, "R5 ptr only");
    read_n(2, "R5 untouched bytes");

    bus_start;
    send({dev, 1'b0}, a);
    check("R7 addr ack", a, 1);
    send(8'h11, a);
    check("R7 ptr ack", a, 1);
    ref_ptr = 8'h11;
    read_n(2, "R7 repeated start read");

    strap = 3'd5; dev = 7'h55;
    read_n(1, "R1 strapped address");
    bus_start;
    send({7'h50, 1'b1}, a);
    check("R1 base address with strap 5 nack", a, 0);
    bus_stop;
    check("R1 released after nack", sda_lo, 0);

    rst_n = 1'b0; wt(3); rst_n = 1'b1; wt(4);
    for (int i = 0; i < 256; i++) ref_mem[i] = img_fn(i);
    ref_ptr = 8'd0;
    check("R9 touched kept through rst_n", touched, 1);
    check("R10 sda_lo after rst_n", sda_lo, 0);
    read_n(1, "R8 ptr cleared by rst_n");
    write_seq(8'h10, d, "R8 ptr only");
    read_n(2, "R8 image restored");

    por_n = 1'b0; wt(3);
    check("R9 cleared by por_n", touched, 0);
    por_n = 1'b1; wt(4);
    check("R4 scoreboard drained", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule